// File: doc/BRIEF.md
# SDRAM Bank Timing Checker

This block sits beside a four-bank SDRAM command bus and watches every command a controller issues. It decodes the active-low select and strobe lines, keeps an open/closed (and auto-closing) state for each bank, and measures in clock cycles how far apart related commands are. When a command breaks a spacing rule, or targets a bank in the wrong state, it raises a violation pulse one cycle later. A code vector on the same cycle has one bit per rule, so several broken rules show together.

All minimum spacings are parameters in clock cycles. The integrator derives each one by dividing the nanosecond figure by the clock period and rounding up. The block only observes and never drives the bus. A command that breaks a timing rule is still assumed to have taken effect. A command issued in an illegal bank state is assumed to have been refused.

Top module: `sdt_timing_checker`

## Requirements
- R1: After reset, both outputs are zero, every bank is closed, and every spacing counter counts as long expired, so any legal command straight after reset raises no violation.
- R2: Only cycles with CKE high and select low carry a command. Strobe lines {RAS#,CAS#,WE#} decode as: 000 mode-register load, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 no operation. An ignored cycle never flags and changes no tracked state.
- R3: A violation for the command in cycle t appears in cycle t+1 for exactly one cycle. `viol_o` is high exactly when `viol_code_o` is nonzero. Code bits are: 0 activate-to-column, 1 precharge-to-activate/refresh, 2 minimum row-open time, 3 maximum row-open time, 4 row cycle, 5 activate-to-activate across banks, 6 mode-load recovery, 7 write recovery, 8 illegal bank state. Every broken rule sets its bit.
- R4: A read or write to an open bank fewer than TRCD cycles after its activate sets bit 0.
- R5: An activate to a bank, or a refresh, fewer than TRP cycles after that bank was precharged (explicitly or by auto precharge) sets bit 1.
- R6: A precharge that closes an open bank fewer than TRAS cycles after its activate sets bit 2.
- R7: A bank still open TRAS_MAX+1 cycles after its activate sets bit 3 for that one cycle only.
- R8: An activate fewer than TRC cycles after the previous activate of the same bank, or after a refresh, sets bit 4. A refresh fewer than TRC cycles after any bank's last activate or refresh also sets bit 4.
- R9: Any activate fewer than TRRD cycles after any previous activate, to any bank, sets bit 5.
- R10: Any command fewer than TMRD cycles after an accepted mode-register load sets bit 6.
- R11: A precharge closing a bank fewer than BURST_LEN-1+TRDL cycles after the last write to that bank sets bit 7.
- R12: Bit 8 is set by any of: an activate to a bank that is not closed; a read or write to a bank that is not open; a precharge to a bank that is closing itself; a mode-register load or refresh while any bank is not closed. Such a command leaves the tracked state unchanged.
- R13: A precharge with A10 high closes every open bank and ignores the bank bits. With A10 low it closes only the bank the bank bits select.
- R14: A read in cycle t with A10 high makes the bank close itself in cycle t+BURST_LEN. A write in cycle t with A10 high makes it close in cycle t+BURST_LEN-1+TRDL. Until then, any read, write, activate or precharge to it is illegal. Its precharge spacing counts from the cycle of self-closure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable line of the bus |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select bits |
| a10_i | input | 1 | Address bit 10 (all-bank / auto-precharge flag) |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 9 | One-hot-per-rule violation code |

## Verification
On every cycle, the embedded properties check three things. The pulse always matches a nonzero code. Back-to-back activates and commands directly after a mode-register load raise their bits. A column command to a closed bank, or a refresh with a bank open, is reported as illegal. Inside each bank, they check that precharge and activate move the bank state, and that a self-closing bank always has a running countdown. The directed scenarios are needed to show the exact cycle boundaries of each spacing rule: the self-closure points after auto-precharged reads and writes, the single-cycle maximum row-open pulse, all-bank versus single-bank precharge, and the combination of several bits in one code.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [2:0] {
    C_NOP, C_MRS, C_REF, C_ACT, C_RD, C_WR, C_PRE, C_BST
  } cmd_e;

  localparam int VW        = 9;
  localparam int V_RCD     = 0;
  localparam int V_RP      = 1;
  localparam int V_RASMIN  = 2;
  localparam int V_RASMAX  = 3;
  localparam int V_RC      = 4;
  localparam int V_RRD     = 5;
  localparam int V_MRD     = 6;
  localparam int V_RDL     = 7;
  localparam int V_ILL     = 8;
endpackage

// File: rtl/sdt_cmd_decode.sv
module sdt_cmd_decode
  import sdt_pkg::*;
(
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = C_NOP;
    if (cke_i && !cs_n_i) begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b000:  cmd_o = C_MRS;
        3'b001:  cmd_o = C_REF;
        3'b011:  cmd_o = C_ACT;
        3'b101:  cmd_o = C_RD;
        3'b100:  cmd_o = C_WR;
        3'b010:  cmd_o = C_PRE;
        3'b110:  cmd_o = C_BST;
        default: cmd_o = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdt_bank.sv
module sdt_bank
  import sdt_pkg::*;
#(
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRAS      = 7,
  parameter int TRAS_MAX  = 20000,
  parameter int TRC       = 10,
  parameter int TRDL      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  cmd_e          cmd_i,
  input  logic          hit_i,
  input  logic          a10_i,
  input  logic          all_idle_i,
  output logic [VW-1:0] viol_o,
  output logic          idle_o
);
  localparam int AW    = $clog2(TRAS_MAX + 3);
  localparam int WRGAP = BURST_LEN - 1 + TRDL;
  localparam int APW   = $clog2(((WRGAP > BURST_LEN) ? WRGAP : BURST_LEN) + 1);
  localparam logic [AW-1:0]  L_TRCD  = AW'(TRCD);
  localparam logic [AW-1:0]  L_TRP   = AW'(TRP);
  localparam logic [AW-1:0]  L_TRAS  = AW'(TRAS);
  localparam logic [AW-1:0]  L_TRC   = AW'(TRC);
  localparam logic [AW-1:0]  L_WRGAP = AW'(WRGAP);
  localparam logic [AW-1:0]  L_OVER  = AW'(TRAS_MAX + 1);
  localparam logic [APW-1:0] L_AP_RD = APW'(BURST_LEN);
  localparam logic [APW-1:0] L_AP_WR = APW'(WRGAP);

  typedef enum logic [1:0] {B_IDLE, B_OPEN, B_AUTO} bstate_e;

  bstate_e        st_q;
  logic [AW-1:0]  act_age_q, pre_age_q, wr_age_q;
  logic [APW-1:0] ap_q;

  logic is_act, is_col, is_pre, is_glob;
  assign is_act  = (cmd_i == C_ACT) && hit_i;
  assign is_col  = ((cmd_i == C_RD) || (cmd_i == C_WR)) && hit_i;
  assign is_pre  = (cmd_i == C_PRE) && (hit_i || a10_i);
  assign is_glob = (cmd_i == C_REF) || (cmd_i == C_MRS);

  always_comb begin
    viol_o = '0;
    if (is_act) begin
      if (st_q != B_IDLE) viol_o[V_ILL] = 1'b1;
      else begin
        viol_o[V_RP] = (pre_age_q < L_TRP);
        viol_o[V_RC] = (act_age_q < L_TRC);
      end
    end
    if (is_col) begin
      if (st_q != B_OPEN) viol_o[V_ILL] = 1'b1;
      else viol_o[V_RCD] = (act_age_q < L_TRCD);
    end
    if (is_pre) begin
      if (st_q == B_AUTO) viol_o[V_ILL] = 1'b1;
      else if (st_q == B_OPEN) begin
        viol_o[V_RASMIN] = (act_age_q < L_TRAS);
        viol_o[V_RDL]    = (wr_age_q < L_WRGAP);
      end
    end
    if (is_glob && (st_q != B_IDLE)) viol_o[V_ILL] = 1'b1;
    if ((cmd_i == C_REF) && all_idle_i) begin
      if (pre_age_q < L_TRP) viol_o[V_RP] = 1'b1;
      if (act_age_q < L_TRC) viol_o[V_RC] = 1'b1;
    end
    if ((st_q == B_OPEN) && (act_age_q == L_OVER)) viol_o[V_RASMAX] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q      <= B_IDLE;
      act_age_q <= '1;
      pre_age_q <= '1;
      wr_age_q  <= '1;
      ap_q      <= '0;
    end else begin
      if (act_age_q != '1) act_age_q <= act_age_q + 1'b1;
      if (pre_age_q != '1) pre_age_q <= pre_age_q + 1'b1;
      if (wr_age_q  != '1) wr_age_q  <= wr_age_q + 1'b1;
      if (ap_q != '0) ap_q <= ap_q - 1'b1;

      if (is_act && (st_q == B_IDLE)) begin
        st_q      <= B_OPEN;
        act_age_q <= AW'(1);
      end
      if (is_col && (st_q == B_OPEN)) begin
        if (cmd_i == C_WR) wr_age_q <= AW'(1);
        if (a10_i) begin
          st_q <= B_AUTO;
          ap_q <= (cmd_i == C_WR) ? L_AP_WR : L_AP_RD;
        end
      end
      if (is_pre && (st_q == B_OPEN)) begin
        st_q      <= B_IDLE;
        pre_age_q <= AW'(1);
      end
      if ((st_q == B_AUTO) && (ap_q == APW'(1))) begin
        st_q      <= B_IDLE;
        pre_age_q <= AW'(1);
      end
      if ((cmd_i == C_REF) && all_idle_i) act_age_q <= AW'(1);
    end
  end

  assign idle_o = (st_q == B_IDLE);

  AST_AUTO_COUNTING: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == B_AUTO) |-> (ap_q != '0)); // R14
  AST_PRE_CLOSES: assert property (@(posedge clk_i) disable iff (rst_i)
    (is_pre && (st_q == B_OPEN)) |=> (st_q == B_IDLE)); // R13
  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
    (is_act && (st_q == B_IDLE)) |=> ((st_q == B_OPEN) && (act_age_q == AW'(1)))); // R12
endmodule

// File: rtl/sdt_timing_checker.sv
module sdt_timing_checker
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRAS      = 7,
  parameter int TRAS_MAX  = 20000,
  parameter int TRC       = 10,
  parameter int TRRD      = 2,
  parameter int TMRD      = 2,
  parameter int TRDL      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic                         cke_i,
  input  logic                         cs_n_i,
  input  logic                         ras_n_i,
  input  logic                         cas_n_i,
  input  logic                         we_n_i,
  input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
  input  logic                         a10_i,
  output logic                         viol_o,
  output logic [VW-1:0]                viol_code_o
);
  localparam int BW = $clog2(NUM_BANKS);
  localparam int GMAX = (TRRD > TMRD) ? TRRD : TMRD;
  localparam int GW = $clog2(GMAX + 2);
  localparam logic [GW-1:0] L_TRRD = GW'(TRRD);
  localparam logic [GW-1:0] L_TMRD = GW'(TMRD);

  cmd_e cmd;
  logic [VW-1:0] bank_v [NUM_BANKS];
  logic [NUM_BANKS-1:0] idle_vec;
  logic all_idle;
  logic [GW-1:0] rrd_age_q, mrs_age_q;
  logic [VW-1:0] code_d;
  logic seen_q;

  sdt_cmd_decode dec_i (
    .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .cmd_o(cmd)
  );

  assign all_idle = &idle_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdt_bank #(
      .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TRAS_MAX(TRAS_MAX),
      .TRC(TRC), .TRDL(TRDL), .BURST_LEN(BURST_LEN)
    ) bank_i (
      .clk_i(clk_i), .rst_i(rst_i), .cmd_i(cmd),
      .hit_i(ba_i == BW'(b)), .a10_i(a10_i), .all_idle_i(all_idle),
      .viol_o(bank_v[b]), .idle_o(idle_vec[b])
    );
  end

  always_comb begin
    code_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) code_d = code_d | bank_v[b];
    if ((cmd == C_ACT) && (rrd_age_q < L_TRRD)) code_d[V_RRD] = 1'b1;
    if ((cmd != C_NOP) && (mrs_age_q < L_TMRD)) code_d[V_MRD] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rrd_age_q   <= '1;
      mrs_age_q   <= '1;
      viol_code_o <= '0;
      viol_o      <= 1'b0;
      seen_q      <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (rrd_age_q != '1) rrd_age_q <= rrd_age_q + 1'b1;
      if (mrs_age_q != '1) mrs_age_q <= mrs_age_q + 1'b1;
      if (cmd == C_ACT) rrd_age_q <= GW'(1);
      if ((cmd == C_MRS) && all_idle) mrs_age_q <= GW'(1);
      viol_code_o <= code_d;
      viol_o      <= |code_d;
    end
  end

  always_comb begin
    AST_PULSE_MATCHES_CODE: assert (viol_o == (viol_code_o != '0)); // R3
  end

  AST_COLUMN_TO_CLOSED: assert property (@(posedge clk_i) disable iff (rst_i)
    (((cmd == C_RD) || (cmd == C_WR)) && idle_vec[ba_i]) |=> viol_code_o[V_ILL]); // R12
  AST_REFRESH_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
    ((cmd == C_REF) && !all_idle) |=> viol_code_o[V_ILL]); // R12

  if (TRRD >= 2) begin : g_rrd_chk
    AST_BACK_TO_BACK_ACT: assert property (@(posedge clk_i) disable iff (rst_i)
      (seen_q && (cmd == C_ACT) && ($past(cmd) == C_ACT)) |=> viol_code_o[V_RRD]); // R9
  end
  if (TMRD >= 2) begin : g_mrd_chk
    AST_CMD_AFTER_MODE: assert property (@(posedge clk_i) disable iff (rst_i)
      (seen_q && (cmd != C_NOP) && ($past(cmd) == C_MRS) && $past(all_idle))
        |=> viol_code_o[V_MRD]); // R10
  end
endmodule

// File: tb/sdt_timing_checker_tb.sv
module sdt_timing_checker_tb_top;
  localparam logic [3:0] P_NOP = 4'b1111;
  localparam logic [3:0] P_MRS = 4'b0000;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_PRE = 4'b0010;

  localparam logic [8:0] E_RCD = 9'h001;
  localparam logic [8:0] E_RP  = 9'h002;
  localparam logic [8:0] E_RMN = 9'h004;
  localparam logic [8:0] E_RMX = 9'h008;
  localparam logic [8:0] E_RC  = 9'h010;
  localparam logic [8:0] E_RRD = 9'h020;
  localparam logic [8:0] E_MRD = 9'h040;
  localparam logic [8:0] E_RDL = 9'h080;
  localparam logic [8:0] E_ILL = 9'h100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic viol;
  logic [8:0] code;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdt_timing_checker #(.TRAS_MAX(40)) dut_i (
    .clk_i(clk), .rst_i(rst), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .a10_i(a10),
    .viol_o(viol), .viol_code_o(code)
  );

  task automatic check_out(input logic [8:0] exp, input string tag);
    checks++;
    if (code !== exp || viol !== (exp != 9'h0)) begin
      fails++;
      $display("FAIL %s code=%b viol=%b expected code=%b viol=%b",
               tag, code, viol, exp, (exp != 9'h0));
    end
  endtask

  // Called at a falling edge; drives one cycle, checks its result one edge later.
  task automatic step(input logic [3:0] p, input logic [1:0] b, input logic a,
                      input logic [8:0] exp, input string tag);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b; a10 = a;
    @(negedge clk);
    check_out(exp, tag);
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(P_NOP, 2'd0, 1'b0, 9'h0, "R2 idle");
  endtask

  task automatic t_reset;
    check_out(9'h0, "R1 outputs after reset");
    step(P_ACT, 2'd0, 1'b0, 9'h0, "R1 activate right after reset");
    idle(6);
    step(P_PRE, 2'd0, 1'b0, 9'h0, "R6 precharge at exact TRAS");
    idle(3);
  endtask

  task automatic t_decode;
    cke = 1'b0;
    step(P_ACT, 2'd1, 1'b0, 9'h0, "R2 activate with CKE low ignored");
    cke = 1'b1;
    step(4'b1101, 2'd1, 1'b0, 9'h0, "R2 select high ignored");
    step(P_RD, 2'd1, 1'b0, E_ILL, "R2 bank still closed after ignored activate");
    idle(2);
  endtask

  task automatic t_spacing;
    step(P_ACT, 2'd1, 1'b0, 9'h0, "R4 open bank 1");
    idle(1);
    step(P_RD, 2'd1, 1'b0, E_RCD, "R4 read too soon");
    step(P_WR, 2'd1, 1'b0, 9'h0, "R4 write at TRCD");
    idle(2);
    step(P_PRE, 2'd1, 1'b0, E_RMN | E_RDL, "R11 R6 R3 early precharge two bits");
    idle(1);
    step(P_ACT, 2'd1, 1'b0, E_RP | E_RC, "R5 R8 activate too soon");
    idle(6);
    step(P_PRE, 2'd1, 1'b0, 9'h0, "R6 legal close");
    idle(3);
  endtask

  task automatic t_rrd_prechg;
    step(P_ACT, 2'd0, 1'b0, 9'h0, "R9 first activate");
    step(P_ACT, 2'd2, 1'b0, E_RRD, "R9 activate next cycle");
    idle(1);
    step(P_ACT, 2'd3, 1'b0, 9'h0, "R9 activate at TRRD");
    idle(6);
    step(P_PRE, 2'd1, 1'b1, 9'h0, "R13 precharge all");
    step(P_RD, 2'd2, 1'b0, E_ILL, "R13 bank 2 closed by all-bank precharge");
    step(P_RD, 2'd3, 1'b0, E_ILL, "R13 bank 3 closed by all-bank precharge");
    idle(3);
    step(P_ACT, 2'd0, 1'b0, 9'h0, "R13 reopen bank 0");
    idle(1);
    step(P_ACT, 2'd1, 1'b0, 9'h0, "R13 open bank 1");
    idle(5);
    step(P_PRE, 2'd0, 1'b0, 9'h0, "R13 single-bank precharge");
    step(P_RD, 2'd1, 1'b0, 9'h0, "R13 bank 1 stays open");
    step(P_RD, 2'd0, 1'b0, E_ILL, "R13 bank 0 closed");
    step(P_PRE, 2'd1, 1'b0, 9'h0, "R13 close bank 1");
    idle(3);
  endtask

  task automatic t_mode_refresh;
    step(P_MRS, 2'd0, 1'b0, 9'h0, "R10 mode load all closed");
    step(P_ACT, 2'd0, 1'b0, E_MRD, "R10 activate right after mode load");
    step(P_REF, 2'd0, 1'b0, E_ILL, "R12 refresh with open bank");
    step(P_MRS, 2'd0, 1'b0, E_ILL, "R12 mode load with open bank");
    idle(4);
    step(P_PRE, 2'd0, 1'b0, 9'h0, "R12 close bank 0");
    step(P_REF, 2'd0, 1'b0, E_RP | E_RC, "R5 R8 refresh too soon");
    idle(2);
    step(P_MRS, 2'd0, 1'b0, 9'h0, "R10 mode load");
    step(P_REF, 2'd0, 1'b0, E_MRD | E_RC, "R10 R8 refresh after mode load");
    idle(9);
    step(P_ACT, 2'd2, 1'b0, 9'h0, "R8 activate TRC after refresh");
    idle(6);
    step(P_PRE, 2'd2, 1'b0, 9'h0, "R6 close bank 2");
    idle(3);
  endtask

  task automatic t_auto;
    step(P_ACT, 2'd0, 1'b0, 9'h0, "R14 open bank 0");
    idle(2);
    step(P_RD, 2'd0, 1'b1, 9'h0, "R14 read with auto precharge");
    idle(1);
    step(P_RD, 2'd0, 1'b0, E_ILL, "R14 read while closing");
    step(P_PRE, 2'd0, 1'b0, E_ILL, "R14 precharge while closing");
    idle(2);
    step(P_ACT, 2'd0, 1'b0, E_RP | E_RC, "R14 R5 activate two after read self-close");
    idle(2);
    step(P_WR, 2'd0, 1'b1, 9'h0, "R14 write with auto precharge");
    idle(6);
    step(P_ACT, 2'd0, 1'b0, E_RP, "R14 activate two after write self-close");
    idle(6);
    step(P_PRE, 2'd0, 1'b0, 9'h0, "R14 close bank 0");
    idle(3);
  endtask

  task automatic t_rasmax;
    step(P_ACT, 2'd3, 1'b0, 9'h0, "R7 open bank 3");
    idle(40);
    step(P_NOP, 2'd0, 1'b0, E_RMX, "R7 row held too long");
    step(P_NOP, 2'd0, 1'b0, 9'h0, "R7 single pulse");
    step(P_PRE, 2'd3, 1'b0, 9'h0, "R7 close bank 3");
    idle(2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_spacing();
    t_rrd_prechg();
    t_mode_refresh();
    t_auto();
    t_rasmax();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule